// File: doc/BRIEF.md
# Parallel-Load Serial-Out Shift Register

This block holds a chain of stages that can be filled all at once from a parallel word and then emptied one bit at a time through a serial output. A low level on the load control copies the word into the chain and keeps copying it for as long as the control stays low. With the load control high, each rising edge of a shift strobe moves every bit one stage toward the output end. The strobe is the OR of two interchangeable pins, a clock pin and an inhibit pin. The serial input fills the vacated first stage. The last stage drives a true and an inverted serial output.

The pins come from outside the system clock domain. Every pin passes through its own synchronizer on the system clock, and strobe edges are found by comparing the synchronized OR with its value one cycle earlier. The output is a plain level with no handshake. Whoever reads it waits for the fixed latency and needs no back-pressure, because the register only changes on a strobe edge or while a load is held.

Top module: `piso_shifter`

## Requirements
- R1: While `load_n` is low, stage k takes `par_in[k]` on every system cycle, whatever the strobe pins and `ser_in` are doing. Bit 0 feeds the first stage and bit STAGES-1 feeds the last stage.
- R2: While `load_n` is high, changes on `par_in` leave the register contents and `q_out` unchanged.
- R3: With `load_n` high, a rising edge of (`shift_clk` OR `shift_inh`) shifts the register one stage toward the last stage, and stage 0 takes `ser_in`. After a load, `q_out` shows bit STAGES-1, then STAGES-2 and so on down to bit 0, and then the serial bits in the order they were shifted in.
- R4: While either strobe pin is held high, a level change or a rising edge on the other pin causes no shift.
- R5: A rising edge on `shift_inh` while `shift_clk` is low shifts exactly as a `shift_clk` edge does.
- R6: `q_out` equals the last stage and `q_out_n` is always its complement.
- R7: A synchronous active-high `rst` clears every stage, so `q_out` = 0 and `q_out_n` = 1. A strobe pin that is already high when reset is released causes no shift.
- R8: If the synchronized strobe OR rises in the same system cycle in which the synchronized `load_n` goes high, no shift occurs. The next shift needs a new rising edge.
- R9: A pin change made before a system clock edge reaches `q_out` after exactly SYNC_STAGES+1 rising edges of `clk` (3 with the default values).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples all pins |
| rst | input | 1 | Synchronous active-high reset |
| shift_clk | input | 1 | Shift strobe pin, interchangeable with shift_inh |
| shift_inh | input | 1 | Second shift strobe pin, ORed with shift_clk |
| ser_in | input | 1 | Serial data entering stage 0 on a shift |
| load_n | input | 1 | Active-low level-sensitive parallel load |
| par_in | input | STAGES | Parallel word; bit 0 goes to the first stage |
| q_out | output | 1 | Last stage, the serial output |
| q_out_n | output | 1 | Complement of q_out |

## Verification
Two functions can land in one system cycle: the release of the parallel load and a strobe edge. The bench provokes this by raising `load_n` and `shift_clk` on the same falling edge of the bench clock, so both pins pass through matched synchronizers and arrive together. It then checks that `q_out` still shows the freshly loaded last bit. It also checks that a strobe level held high across the release does not count as an edge, and that a separate low-to-high edge afterwards shifts one position. A load asserted while the strobe is high, and a parallel word changed while the load is held, are judged against a queue model that applies load before shift.

// File: rtl/piso_pkg.sv
package piso_pkg;
  // Per-cycle action chosen for the stage chain
  typedef enum logic [1:0] {
    OP_HOLD  = 2'd0,
    OP_LOAD  = 2'd1,
    OP_SHIFT = 2'd2
  } stage_op_e;
endpackage

// File: rtl/pin_sync.sv
module pin_sync #(
  parameter int unsigned     W       = 1,
  parameter int unsigned     DEPTH   = 2,
  parameter logic [W-1:0]    RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [DEPTH-1:0][W-1:0] pipe;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < DEPTH; i++) pipe[i] <= RST_VAL;
    end else begin
      pipe[0] <= d;
      for (int i = 1; i < DEPTH; i++) pipe[i] <= pipe[i-1];
    end
  end

  assign q = pipe[DEPTH-1];
endmodule

// File: rtl/shift_trigger.sv
module shift_trigger
  import piso_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      ld_n,
  input  logic      strobe_a,
  input  logic      strobe_b,
  output stage_op_e op
);
  logic strobe_or;
  logic or_prev;
  logic ld_prev;

  assign strobe_or = strobe_a | strobe_b;

  // History resets high so a level already high at release is not an edge
  always_ff @(posedge clk) begin
    if (rst) begin
      or_prev <= 1'b1;
      ld_prev <= 1'b1;
    end else begin
      or_prev <= strobe_or;
      ld_prev <= ld_n;
    end
  end

  always_comb begin
    if (!ld_n)
      op = OP_LOAD;
    else if (strobe_or && !or_prev && ld_prev)
      op = OP_SHIFT;
    else
      op = OP_HOLD;
  end
endmodule

// File: rtl/stage_chain.sv
module stage_chain
  import piso_pkg::*;
#(
  parameter int unsigned STAGES = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  stage_op_e         op,
  input  logic              ser,
  input  logic [STAGES-1:0] par,
  output logic [STAGES-1:0] stages
);
  generate
    for (genvar k = 0; k < STAGES; k++) begin : g_stage
      logic from_prev;
      logic bit_q;
      if (k == 0) begin : g_head
        assign from_prev = ser;
      end else begin : g_body
        assign from_prev = stages[k-1];
      end
      always_ff @(posedge clk) begin
        if (rst)
          bit_q <= 1'b0;
        else begin
          unique case (op)
            OP_LOAD:  bit_q <= par[k];
            OP_SHIFT: bit_q <= from_prev;
            default:  bit_q <= bit_q;
          endcase
        end
      end
      assign stages[k] = bit_q;
    end
  endgenerate
endmodule

// File: rtl/piso_shifter.sv
module piso_shifter
  import piso_pkg::*;
#(
  parameter int unsigned STAGES      = 8,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              shift_clk,
  input  logic              shift_inh,
  input  logic              ser_in,
  input  logic              load_n,
  input  logic [STAGES-1:0] par_in,
  output logic              q_out,
  output logic              q_out_n
);
  localparam int unsigned LAST = STAGES - 1;

  logic              ld_n_s;
  logic              clk_s;
  logic              inh_s;
  logic              ser_s;
  logic [STAGES-1:0] par_s;
  logic [STAGES-1:0] stages;
  stage_op_e         op;

  // Control pins reset to their idle-high level
  pin_sync #(.W(3), .DEPTH(SYNC_STAGES), .RST_VAL(3'b111)) u_sync_ctl (
    .clk(clk), .rst(rst),
    .d({load_n, shift_inh, shift_clk}),
    .q({ld_n_s, inh_s, clk_s})
  );

  pin_sync #(.W(STAGES + 1), .DEPTH(SYNC_STAGES), .RST_VAL('0)) u_sync_dat (
    .clk(clk), .rst(rst),
    .d({ser_in, par_in}),
    .q({ser_s, par_s})
  );

  shift_trigger u_trig (
    .clk(clk), .rst(rst),
    .ld_n(ld_n_s), .strobe_a(clk_s), .strobe_b(inh_s),
    .op(op)
  );

  stage_chain #(.STAGES(STAGES)) u_chain (
    .clk(clk), .rst(rst),
    .op(op), .ser(ser_s), .par(par_s),
    .stages(stages)
  );

  assign q_out   = stages[LAST];
  assign q_out_n = ~stages[LAST];
endmodule

// File: rtl/piso_shifter_chk.sv
module piso_shifter_chk #(
  parameter int unsigned STAGES = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              ld_n_s,
  input logic              clk_s,
  input logic              inh_s,
  input logic              ser_s,
  input logic [STAGES-1:0] par_s,
  input logic [STAGES-1:0] stages,
  input logic              q_out,
  input logic              q_out_n
);
  logic c_or_prev;
  logic c_ld_prev;
  logic c_or;
  logic c_rise;

  assign c_or   = clk_s | inh_s;
  assign c_rise = c_or & ~c_or_prev;

  always_ff @(posedge clk) begin
    if (rst) begin
      c_or_prev <= 1'b1;
      c_ld_prev <= 1'b1;
    end else begin
      c_or_prev <= c_or;
      c_ld_prev <= ld_n_s;
    end
  end

  AST_LOAD_COPIES: assert property (@(posedge clk) disable iff (rst)
    !ld_n_s |=> stages == $past(par_s)); // R1

  AST_SHIFT_MOVES: assert property (@(posedge clk) disable iff (rst)
    (ld_n_s && c_ld_prev && c_rise) |=>
      stages == {$past(stages[STAGES-2:0]), $past(ser_s)}); // R3

  AST_HOLD_NO_EDGE: assert property (@(posedge clk) disable iff (rst)
    (ld_n_s && !c_rise) |=> $stable(stages)); // R4

  AST_RELEASE_EDGE_IGNORED: assert property (@(posedge clk) disable iff (rst)
    (ld_n_s && !c_ld_prev && c_rise) |=> $stable(stages)); // R8

  AST_OUT_LAST: assert property (@(posedge clk) disable iff (rst)
    q_out == stages[STAGES-1]); // R6

  AST_OUT_COMPLEMENT: assert property (@(posedge clk) disable iff (rst)
    q_out_n == !q_out); // R6

  AST_RESET_CLEARS: assert property (@(posedge clk)
    $past(rst) |-> (stages == '0)); // R7
endmodule

bind piso_shifter piso_shifter_chk #(.STAGES(STAGES)) u_chk (
  .clk(clk), .rst(rst),
  .ld_n_s(ld_n_s), .clk_s(clk_s), .inh_s(inh_s),
  .ser_s(ser_s), .par_s(par_s), .stages(stages),
  .q_out(q_out), .q_out_n(q_out_n)
);

// File: tb/sim_piso_shifter.sv
module sim_piso_shifter;
  localparam int N = 8;

  logic clk = 1'b0;
  logic rst, shift_clk, shift_inh, ser_in, load_n;
  logic [N-1:0] par_in;
  logic q_out, q_out_n;

  int n_run = 0;
  int n_bad = 0;

  always #4 clk = ~clk;

  piso_shifter #(.STAGES(N), .SYNC_STAGES(2)) u0 (
    .clk(clk), .rst(rst), .shift_clk(shift_clk), .shift_inh(shift_inh),
    .ser_in(ser_in), .load_n(load_n), .par_in(par_in),
    .q_out(q_out), .q_out_n(q_out_n)
  );

  // {load_n, shift_clk, shift_inh, ser_in, par_in[7:0]}
  localparam int NV = 29;
  localparam logic [11:0] VEC [NV] = '{
    {4'b0000, 8'hB2}, {4'b1001, 8'h00}, {4'b1101, 8'hFF}, {4'b1001, 8'hFF},
    {4'b1101, 8'h00}, {4'b1000, 8'h00}, {4'b1100, 8'h00}, {4'b1000, 8'h00},
    {4'b1101, 8'h00}, {4'b1001, 8'h00}, {4'b1011, 8'h00}, {4'b1001, 8'h00},
    {4'b1010, 8'h00}, {4'b1000, 8'h00}, {4'b1100, 8'h00}, {4'b1110, 8'h00},
    {4'b1010, 8'h00}, {4'b1111, 8'h00}, {4'b1001, 8'h00}, {4'b1101, 8'h00},
    {4'b1000, 8'h00}, {4'b1100, 8'h00}, {4'b1000, 8'h00}, {4'b0100, 8'h5A},
    {4'b0001, 8'hC3}, {4'b1101, 8'h00}, {4'b1101, 8'h00}, {4'b1001, 8'h00},
    {4'b1101, 8'h00}
  };

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(input string what, input logic act, input logic exp);
    n_run++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %b expected %b", what, act, exp);
    end
  endtask

  task automatic chk_out(input string what, input logic exp);
    chk(what, q_out, exp);
    chk({what, " R6 complement"}, q_out_n, ~exp);
  endtask

  initial begin
    #(8 * 200000);
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_bad);
    $finish;
  end

  initial begin
    logic [N-1:0] model;
    logic prev_or, prev_ld, or_v;
    rst = 1'b1; shift_clk = 1'b1; shift_inh = 1'b0; ser_in = 1'b1;
    load_n = 1'b1; par_in = '0;
    step(3);
    rst = 1'b0;
    step(4);
    chk_out("R7 reset state", 1'b0);

    // Strobe high at release must not shift: 7 clean edges keep the ones short of q_out
    for (int i = 0; i < 7; i++) begin
      shift_clk = 1'b0; step(4);
      shift_clk = 1'b1; step(4);
    end
    chk_out("R7 no spurious shift at release", 1'b0);
    shift_clk = 1'b0; step(4);
    shift_clk = 1'b1; step(4);
    chk_out("R3 eighth edge brings first serial bit", 1'b1);

    // Latency of a load through the synchronizers
    shift_clk = 1'b0; load_n = 1'b0; par_in = 8'h00; step(4);
    chk_out("R1 load zero word", 1'b0);
    par_in = 8'h80;
    step(2);
    chk_out("R9 unchanged after two edges", 1'b0);
    step(1);
    chk_out("R9 changed after three edges", 1'b1);

    // Table walk against a queue model
    load_n = 1'b1; shift_clk = 1'b0; shift_inh = 1'b0; ser_in = 1'b0;
    step(4);
    model = 8'h80; prev_or = 1'b0; prev_ld = 1'b1;
    for (int v = 0; v < NV; v++) begin
      string tag;
      {load_n, shift_clk, shift_inh, ser_in, par_in} = VEC[v];
      step(4);
      or_v = shift_clk | shift_inh;
      if (!load_n) begin
        model = par_in;
        tag = "R1 load";
      end else if (or_v && !prev_or && prev_ld) begin
        model = {model[N-2:0], ser_in};
        tag = shift_inh && !shift_clk ? "R5 inhibit-pin shift" : "R3 shift";
      end else if (or_v && !prev_or) begin
        tag = "R8 edge at load release";
      end else begin
        tag = "R2/R4 hold";
      end
      prev_or = or_v;
      prev_ld = load_n;
      chk_out($sformatf("%s vector %0d", tag, v), model[N-1]);
    end

    $display("[TB] %0d tests run, %0d failed", n_run, n_bad);
    $finish;
  end
endmodule